// File: doc/BRIEF.md
# Shared Request-Response Transaction Engine

Three client state machines need to talk to a peer over one channel. Rather than giving each client its own copy of the send-and-wait sequence, this engine runs one shared sequence. A client places its packet on its packet lane and raises its request. A round-robin arbiter picks one waiting client. The engine records that client's index as a return tag, sends the packet on a valid/ready transmit port, and then waits for a reply.

The wait ends when a reply arrives or when a programmable cycle limit expires. Either way, the engine gives a one-cycle completion pulse to the tagged client only. The reply data, or a timeout flag with zero data, is valid in that same cycle. The engine then goes idle and can grant the next client. Because the arbiter rotates, a client that keeps requesting cannot lock out the others. Because of the timeout, a peer that never answers cannot hang the channel.

Top module: `txn_share_engine`

## Requirements
- R1: After a synchronous active-low reset, `cli_gnt`, `cli_done`, `tx_valid`, `cli_tmo` and `cli_rdata` are all zero. The round-robin pointer starts at client 0, so if all clients request at once, client 0 is granted first.
- R2: `cli_gnt` is one-hot or zero. A grant lasts exactly one cycle and goes only to a client whose request bit is high. A new grant is issued only from the idle state, so no other grant appears until the current transaction has finished.
- R3: After a grant, the pointer moves to the client after the granted one, wrapping from the last client to client 0. Among the pending requests, the first index at or after the pointer, counting upward with wrap, wins.
- R4: The granted client's packet is captured in the grant cycle. From the next cycle, `tx_valid` is high with that packet on `tx_data`. Both stay unchanged until a cycle in which `tx_ready` is high.
- R5: After the transmit handshake the engine waits. If `rx_valid` is high in a waiting cycle, then in the next cycle only the tagged client's bit of `cli_done` is high, `cli_rdata` carries the captured `rx_data`, and `cli_tmo` is 0.
- R6: The wait counter is 0 in the first waiting cycle and counts up by one per cycle. If `rx_valid` is low in the cycle where the counter equals `tmo_limit`, then in the next cycle the tagged client gets its done pulse with `cli_tmo` = 1 and `cli_rdata` = 0. With a limit of L, the wait therefore lasts L+1 cycles.
- R7: `cli_done` is one-hot or zero and lasts one cycle. Outside that cycle, `cli_rdata` and `cli_tmo` are zero. The first new grant can appear two cycles after a done pulse.
- R8: `rx_valid` is ignored outside the waiting state. It produces no done pulse and does not change any later reply.
- R9: If `rx_valid` is high in the same cycle the counter reaches `tmo_limit`, the reply wins: its data is returned and `cli_tmo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cli_req | input | N_CLI | Request bit per client; held high until granted |
| cli_pkt | input | N_CLI*PKT_W | Packet lanes; client i uses bits [i*PKT_W +: PKT_W] |
| cli_gnt | output | N_CLI | One-cycle one-hot grant |
| tx_valid | output | 1 | Packet on `tx_data` is valid |
| tx_data | output | PKT_W | Outgoing packet |
| tx_ready | input | 1 | Peer accepts the packet |
| rx_valid | input | 1 | Reply present |
| rx_data | input | RSP_W | Reply payload |
| tmo_limit | input | TMO_W | Wait limit, in cycles minus one |
| cli_done | output | N_CLI | One-cycle completion pulse to the tagged client |
| cli_rdata | output | RSP_W | Reply data, valid with `cli_done` |
| cli_tmo | output | 1 | Timeout status, valid with `cli_done` |

## Verification
The bench builds the engine with three clients, 8-bit packet and reply widths, and a 4-bit timeout counter. With these values, timeout limits of 0, 3 and 4 expire within a few cycles, and the bench can exercise the reply arriving in the very cycle the counter expires. Having three clients lets the pointer wrap from the last client back to the first, and lets requests pile up while the engine is busy, so the rotation order and the idle-only grant rule can both be observed.

// File: rtl/txn_pkg.sv
// Package: shared types for the transaction engine.
// Holds the engine state encoding used by the top module.
package txn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRANT,
        ST_SEND,
        ST_WAIT,
        ST_DONE
    } eng_state_t;
endpackage

// File: rtl/rr_pick.sv
// Round-robin picker. It selects the first requesting client at or after
// the pointer, counting upward and wrapping. The pointer moves past a
// client when the owner signals that client was granted.
// Assumes: advance is a single-cycle strobe and adv_from < N.
module rr_pick #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    input  logic [IW-1:0] adv_from,
    output logic          win_valid,
    output logic [IW-1:0] win_idx
);
    logic [IW-1:0] ptr_q;

    // Search the request vector, starting from the pointer.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = int'(ptr_q) + k;
            if (c >= N) c = c - N;
            if (!win_valid && req[c]) begin
                win_valid = 1'b1;
                win_idx   = IW'(c);
            end
        end
    end

    // Move the pointer to the client after the one just granted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (advance)
            ptr_q <= (adv_from == IW'(N - 1)) ? '0 : adv_from + 1'b1;
    end
endmodule

// File: rtl/resp_timer.sv
// Reply wait counter. It is cleared when a wait starts and counts while
// the engine waits. It reports expiry once the count reaches the limit.
// Assumes: limit is stable during a wait.
module resp_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    // Expiry is flagged once the count has reached the limit.
    assign expired = run && (cnt_q >= limit);

    // Clear on wait entry; count while waiting, saturating at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (run && !expired)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/txn_share_engine.sv
// Shared transaction engine. One send/wait sequence serves N_CLI clients.
// Round-robin arbitration runs from idle only. The index of the granted
// client is latched as a return tag. The packet goes out on a valid/ready
// port. The reply, or a timeout, is returned to the tagged client alone.
// Assumes: a client holds its request and packet until its grant cycle.
module txn_share_engine
    import txn_pkg::*;
#(
    parameter int N_CLI = 3,
    parameter int PKT_W = 8,
    parameter int RSP_W = 8,
    parameter int TMO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CLI-1:0]   cli_req,
    input  logic [N_CLI*PKT_W-1:0] cli_pkt,
    output logic [N_CLI-1:0]   cli_gnt,
    output logic               tx_valid,
    output logic [PKT_W-1:0]   tx_data,
    input  logic               tx_ready,
    input  logic               rx_valid,
    input  logic [RSP_W-1:0]   rx_data,
    input  logic [TMO_W-1:0]   tmo_limit,
    output logic [N_CLI-1:0]   cli_done,
    output logic [RSP_W-1:0]   cli_rdata,
    output logic               cli_tmo
);
    localparam int IW = (N_CLI > 1) ? $clog2(N_CLI) : 1;

    eng_state_t       state_q;
    logic [IW-1:0]    tag_q;
    logic [PKT_W-1:0] pkt_q;
    logic [RSP_W-1:0] rdata_q;
    logic             tmo_q;
    logic             win_valid;
    logic [IW-1:0]    win_idx;
    logic             expired;
    logic [PKT_W-1:0] lane [N_CLI];

    // Split the flat packet bus into per-client lanes.
    for (genvar g = 0; g < N_CLI; g++) begin : g_lane
        assign lane[g] = cli_pkt[g*PKT_W +: PKT_W];
    end

    rr_pick #(.N(N_CLI), .IW(IW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cli_req),
        .advance   (state_q == ST_GRANT),
        .adv_from  (tag_q),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    resp_timer #(.TW(TMO_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == ST_SEND),
        .run     (state_q == ST_WAIT),
        .limit   (tmo_limit),
        .expired (expired)
    );

    // Sequence: grant, send, wait for reply or timeout, return to tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tag_q   <= '0;
            pkt_q   <= '0;
            rdata_q <= '0;
            tmo_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (win_valid) begin
                    tag_q   <= win_idx;
                    state_q <= ST_GRANT;
                end
                ST_GRANT: begin
                    pkt_q   <= lane[tag_q];
                    state_q <= ST_SEND;
                end
                ST_SEND: if (tx_ready) state_q <= ST_WAIT;
                ST_WAIT: if (rx_valid) begin
                    rdata_q <= rx_data;
                    tmo_q   <= 1'b0;
                    state_q <= ST_DONE;
                end else if (expired) begin
                    rdata_q <= '0;
                    tmo_q   <= 1'b1;
                    state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode the tag into per-client grant and done strobes.
    for (genvar g = 0; g < N_CLI; g++) begin : g_strobe
        assign cli_gnt[g]  = (state_q == ST_GRANT) && (tag_q == IW'(g));
        assign cli_done[g] = (state_q == ST_DONE)  && (tag_q == IW'(g));
    end

    // Drive the transmit port and the reply outputs.
    assign tx_valid  = (state_q == ST_SEND);
    assign tx_data   = pkt_q;
    assign cli_rdata = (state_q == ST_DONE) ? rdata_q : '0;
    assign cli_tmo   = (state_q == ST_DONE) && tmo_q;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cli_gnt)); // R2
    AST_GNT_WAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|cli_gnt) |-> (|(cli_gnt & $past(cli_req)))); // R2
    AST_GNT_TO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (|cli_gnt) |=> tx_valid); // R4
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R4
    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cli_done)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|cli_done) |=> !(|cli_done)); // R7
    AST_TMO_NODATA: assert property (@(posedge clk) disable iff (!rst_n)
        cli_tmo |-> ((|cli_done) && (cli_rdata == '0))); // R6
    AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|cli_done) |-> (!cli_tmo && (cli_rdata == '0))); // R7
endmodule

// File: tb/txn_share_engine_test.sv
module txn_share_engine_test;
    localparam int N  = 3;
    localparam int PW = 8;
    localparam int RW = 8;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  cli_req = '0;
    logic [N*PW-1:0] cli_pkt = '0;
    logic [N-1:0]  cli_gnt;
    logic          tx_valid;
    logic [PW-1:0] tx_data;
    logic          tx_ready = 1'b0;
    logic          rx_valid = 1'b0;
    logic [RW-1:0] rx_data = '0;
    logic [TW-1:0] tmo_limit = 4'd5;
    logic [N-1:0]  cli_done;
    logic [RW-1:0] cli_rdata;
    logic          cli_tmo;

    txn_share_engine #(.N_CLI(N), .PKT_W(PW), .RSP_W(RW), .TMO_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .cli_req(cli_req), .cli_pkt(cli_pkt),
        .cli_gnt(cli_gnt), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .tmo_limit(tmo_limit), .cli_done(cli_done), .cli_rdata(cli_rdata),
        .cli_tmo(cli_tmo)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    string ctx = "R1";
    bit cmp_on = 0, wd_hit = 0;
    int cyc = 0, done_seen = 0;
    logic [N-1:0] want = '0;
    int seq [N] = '{0, 0, 0};
    int ready_delay = 0, resp_delay = 2, send_cnt = 0, wait_cnt = 0;
    bit spur = 0;
    int rsp_seq = 0;
    int gnt_log [$];

    // Reference model: phase 0 idle, 1 grant, 2 send, 3 wait, 4 done.
    int m_phase = 0, m_tag = 0, m_ptr = 0, m_cnt = 0;
    logic [PW-1:0] m_pkt = '0;
    logic [RW-1:0] m_data = '0;
    bit m_tmo = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_tag = 0; m_ptr = 0; m_cnt = 0;
            m_pkt = '0; m_data = '0; m_tmo = 0;
        end else begin
            case (m_phase)
                0: begin
                    for (int k = 0; k < N; k++) begin
                        int c;
                        c = (m_ptr + k) % N;
                        if (m_phase == 0 && cli_req[c]) begin
                            m_tag = c; m_phase = 1;
                        end
                    end
                end
                1: begin
                    m_pkt = cli_pkt[m_tag*PW +: PW];
                    m_ptr = (m_tag + 1) % N;
                    m_phase = 2;
                end
                2: if (tx_ready) begin m_phase = 3; m_cnt = 0; end
                3: begin
                    if (rx_valid) begin
                        m_data = rx_data; m_tmo = 0; m_phase = 4;
                    end else if (m_cnt >= int'(tmo_limit)) begin
                        m_data = '0; m_tmo = 1; m_phase = 4;
                    end else m_cnt++;
                end
                default: m_phase = 0;
            endcase
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare on the falling edge, then drive the clients and the peer.
    always @(negedge clk) begin
        logic [N-1:0] eg, ed;
        cyc++;
        if (cyc > 100000 && !wd_hit) begin
            wd_hit = 1; checks++; errors++;
            $display("FAIL watchdog: run hung, actual=busy expected=finished");
        end
        if (cmp_on) begin
            eg = '0; ed = '0;
            if (m_phase == 1) eg[m_tag] = 1'b1;
            if (m_phase == 4) ed[m_tag] = 1'b1;
            chk((ctx == "R3") ? "R3" : "R2", "cli_gnt", 32'(cli_gnt), 32'(eg));
            chk("R4", "tx_valid", 32'(tx_valid), 32'(m_phase == 2));
            if (m_phase == 2) chk("R4", "tx_data", 32'(tx_data), 32'(m_pkt));
            chk(ctx, "cli_done", 32'(cli_done), 32'(ed));
            chk(ctx, "cli_rdata", 32'(cli_rdata), 32'((m_phase == 4) ? m_data : '0));
            chk(ctx, "cli_tmo", 32'(cli_tmo), 32'((m_phase == 4) && m_tmo));
        end
        if (|cli_gnt) for (int i = 0; i < N; i++) if (cli_gnt[i]) gnt_log.push_back(i);
        for (int i = 0; i < N; i++) begin
            if (cli_gnt[i]) want[i] = 1'b0;
            if (cli_done[i]) seq[i]++;
            cli_pkt[i*PW +: PW] = PW'(8'h10 * (i + 1) + seq[i]);
        end
        if (|cli_done) done_seen++;
        cli_req = want;
        if (m_phase == 2) begin tx_ready = (send_cnt >= ready_delay); send_cnt++; end
        else begin tx_ready = 1'b0; send_cnt = 0; end
        if (m_phase == 3) begin
            rx_valid = (wait_cnt == resp_delay); wait_cnt++;
        end else begin
            rx_valid = spur; wait_cnt = 0;
        end
        rsp_seq++;
        rx_data = RW'(8'hA0 + rsp_seq);
    end

    task automatic run(input string c, input logic [N-1:0] w, input int n);
        int target;
        ctx = c;
        @(posedge clk); #1;
        want = w;
        target = done_seen + n;
        while (done_seen < target && !wd_hit) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset gnt", 32'(cli_gnt), 0);
        chk("R1", "reset done", 32'(cli_done), 0);
        chk("R1", "reset tx_valid", 32'(tx_valid), 0);
        chk("R1", "reset tmo", 32'(cli_tmo), 0);
        chk("R1", "reset rdata", 32'(cli_rdata), 0);
        rst_n = 1'b1;
        cmp_on = 1;
        // R1 and R3: all request together; expect order 0, 1, 2.
        run("R3", 3'b111, 3);
        chk("R1", "first grant", 32'(gnt_log.size() > 0 ? gnt_log[0] : 9), 0);
        chk("R3", "second grant", 32'(gnt_log.size() > 1 ? gnt_log[1] : 9), 1);
        chk("R3", "third grant", 32'(gnt_log.size() > 2 ? gnt_log[2] : 9), 2);
        // R3: the pointer has wrapped to 0, so client 0 now beats client 2.
        gnt_log.delete();
        run("R3", 3'b101, 2);
        chk("R3", "wrap grant", 32'(gnt_log.size() > 0 ? gnt_log[0] : 9), 0);
        resp_delay = 3;
        run("R5", 3'b010, 1);
        ready_delay = 4;
        run("R4", 3'b001, 1);
        ready_delay = 0;
        resp_delay = -1; tmo_limit = 4'd4;
        run("R6", 3'b100, 1);
        tmo_limit = 4'd0;
        run("R6", 3'b010, 1);
        tmo_limit = 4'd3; resp_delay = 3;
        run("R9", 3'b001, 1);
        tmo_limit = 4'd5; resp_delay = 2; spur = 1;
        run("R8", 3'b011, 2);
        spur = 0; resp_delay = 6; tmo_limit = 4'd9;
        run("R2", 3'b111, 3);
        run("R7", 3'b110, 2);
        chk("R7", "done pulses seen", 32'(done_seen), 17);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule